// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches a two-wire SMBus-style bus and raises timeout flags. It samples the clock line (SCL) and the data line (SDA) through a two-flop synchronizer. It also takes this device's own request to stretch the clock, and a flag that says when this device is driving SCL low for any reason. All time is counted in units of a one-cycle prescaled `tick`, and every counter saturates at its maximum instead of wrapping.

The block has two timers on the high side of the bus. The first fires when both lines stay high for `high_max` ticks, which lets a master treat a started but never-stopped bus as idle. The second fires when SCL stays high with SDA held low for `stuck_max` ticks. On the low side the block adds up this device's clock-extension time. In master mode the sum restarts at every START, ACK slot and STOP. In slave mode it runs from START to STOP. In master mode the block also adds up the time a remote slave holds SCL low. When that time goes past the slave limit, the block requests an abort that takes effect at the next byte boundary.

START, STOP and ACK-slot events come in as one-cycle pulses from an external decoder. Every flag is sticky and is cleared by its own clear strobe. One interrupt output combines two of the flags, each under its own enable.

Top module: `smbus_tmo_mon`

## Requirements
- R1: Time counting advances only in cycles where `tick` is 1. With `tick` held at 0, no level on the lines sets any flag.
- R2: When the synchronized SCL and SDA are both high for `high_max` consecutive ticks, flag bit 0 (bus-high timeout) sets. A shorter stretch does not set it. Breaking the condition for a single sample restarts the count.
- R3: `busy` sets on `start_evt` and clears on `stop_evt`. `bus_free` is 1 in the cycle that flag bit 0 rises, and also whenever `busy` and flag bit 0 are both 1.
- R4: When the synchronized SCL is high and SDA is low for `stuck_max` consecutive ticks, flag bit 1 (stuck-data timeout) sets. A shorter stretch does not set it.
- R5: `irq` = (flag bit 1 AND `irq_en[0]`) OR (flag bit 4 AND `irq_en[1]`).
- R6: In master mode, ticks with `stretch_req` high are added up between consecutive START, ACK-slot and STOP events. A sum above `mext_max` sets flag bit 2 (master extend) and flag bit 4 (SCL-low timeout).
- R7: In slave mode, the sum of R6 is not restarted by ACK-slot events. A sum above `sext_max` sets flag bit 3 (slave extend) and flag bit 4.
- R8: In master mode, while busy, ticks with SCL low and `own_scl_low` at 0 are added up from START. A sum above `sext_max` arms an abort. Flag bit 5 (abort request) sets only at the next `ack_evt` or `stop_evt`, not when the abort is armed.
- R9: All flags are 0 after reset and stay set until a 1 on the matching `flag_clr` bit. A clear and a set in the same cycle leave the flag set.
- R10: Counters saturate at all-ones. A condition held past the counter's range keeps the flag firing again after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled time-base pulse |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| stretch_req | input | 1 | This device is extending SCL low |
| own_scl_low | input | 1 | This device drives SCL low (for any reason) |
| start_evt | input | 1 | START seen, one-cycle pulse |
| stop_evt | input | 1 | STOP seen, one-cycle pulse |
| ack_evt | input | 1 | ACK slot ended, one-cycle pulse |
| master_mode | input | 1 | 1 = master, 0 = slave |
| high_max | input | CW | Bus-high timeout, in ticks |
| stuck_max | input | CW | Stuck-data timeout, in ticks |
| mext_max | input | CW | Master per-byte extension limit |
| sext_max | input | CW | Slave per-message extension limit |
| irq_en | input | 2 | Interrupt enables: bit0 stuck, bit1 SCL-low |
| flag_clr | input | 6 | Per-flag clear strobes |
| flags | output | 6 | Sticky flags: 0 high, 1 stuck, 2 mext, 3 sext, 4 SCL-low, 5 abort |
| busy | output | 1 | Bus busy between START and STOP |
| bus_free | output | 1 | Bus may be treated as free |
| irq | output | 1 | Module interrupt |

## Verification
A vector table drives the four SCL/SDA level pairs, each held for short and for long times. Only the both-high pair may set the high flag, and only the clock-high/data-low pair may set the stuck flag. The short holds show that a timer fires on reaching its limit and not before. Directed sequences compare two stretches split by an ACK slot with the same stretches not split by one. In master mode the split stretches must stay quiet and the unsplit ones must fire. In slave mode the split stretches must fire, since ACK slots do not restart the slave sum. Further cases cover the abort held until the next byte boundary, the bus-free rules around START and STOP, clear and set in the same cycle, tick gating, and a hold past the counter range.

// File: rtl/smbus_tmo_pkg.sv
package smbus_tmo_pkg;
    localparam int FLAG_N = 6;

    typedef struct packed {
        logic abort;
        logic sltf;
        logic sext;
        logic mext;
        logic stk;
        logic hto;
    } flags_t;
endpackage

// File: rtl/smbus_sync2.sv
module smbus_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/smbus_hold_timer.sv
module smbus_hold_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (tick && !(&cnt_q))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = run && (cnt_q >= limit);

    // R10
    timer_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (&cnt_q)) |=> ((&cnt_q) || (cnt_q == '0)));
endmodule

// File: rtl/smbus_ext_accum.sv
module smbus_ext_accum #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          seg_clr,
    input  logic          grow,
    input  logic [CW-1:0] limit,
    output logic          over
);
    logic [CW-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (seg_clr)
            acc_d = '0;
        else if (grow && tick && !(&acc_q))
            acc_d = acc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign over = acc_q > limit;

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seg_clr && (&acc_q)) |=> (&acc_q));
endmodule

// File: rtl/smbus_tmo_mon.sv
module smbus_tmo_mon
    import smbus_tmo_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              stretch_req,
    input  logic              own_scl_low,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              ack_evt,
    input  logic              master_mode,
    input  logic [CW-1:0]     high_max,
    input  logic [CW-1:0]     stuck_max,
    input  logic [CW-1:0]     mext_max,
    input  logic [CW-1:0]     sext_max,
    input  logic [1:0]        irq_en,
    input  logic [FLAG_N-1:0] flag_clr,
    output logic [FLAG_N-1:0] flags,
    output logic              busy,
    output logic              bus_free,
    output logic              irq
);
    typedef struct packed {
        flags_t flg;
        logic   busy;
        logic   pend;
        logic   hto_rise;
    } st_t;

    st_t    st_d, st_q;
    flags_t set_v;

    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       hi_hit, stk_hit;
    logic       own_over, rem_over;
    logic       own_clr, rem_clr, rem_grow;

    smbus_sync2 #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    smbus_hold_timer #(.CW(CW)) u_hi_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(scl_s & sda_s),
        .limit(high_max), .hit(hi_hit)
    );

    smbus_hold_timer #(.CW(CW)) u_stk_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(scl_s & ~sda_s),
        .limit(stuck_max), .hit(stk_hit)
    );

    assign own_clr  = start_evt | stop_evt | (master_mode & ack_evt);
    assign rem_clr  = start_evt | stop_evt;
    assign rem_grow = master_mode & st_q.busy & ~scl_s & ~own_scl_low;

    smbus_ext_accum #(.CW(CW)) u_own_acc (
        .clk(clk), .rst_n(rst_n), .tick(tick), .seg_clr(own_clr),
        .grow(stretch_req), .limit(master_mode ? mext_max : sext_max),
        .over(own_over)
    );

    smbus_ext_accum #(.CW(CW)) u_rem_acc (
        .clk(clk), .rst_n(rst_n), .tick(tick), .seg_clr(rem_clr),
        .grow(rem_grow), .limit(sext_max), .over(rem_over)
    );

    always_comb begin
        set_v       = '0;
        set_v.hto   = hi_hit;
        set_v.stk   = stk_hit;
        set_v.mext  = master_mode & own_over;
        set_v.sext  = ~master_mode & own_over;
        set_v.sltf  = set_v.mext | set_v.sext;
        set_v.abort = st_q.pend & (ack_evt | stop_evt);

        st_d          = st_q;
        st_d.flg      = flags_t'((st_q.flg & ~flag_clr) | set_v);
        st_d.hto_rise = set_v.hto & ~st_q.flg.hto;

        if (start_evt)     st_d.busy = 1'b1;
        else if (stop_evt) st_d.busy = 1'b0;

        if (start_evt || set_v.abort) st_d.pend = 1'b0;
        else if (master_mode && rem_over) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags    = st_q.flg;
    assign busy     = st_q.busy;
    assign bus_free = st_q.hto_rise | (st_q.busy & st_q.flg.hto);
    assign irq      = (st_q.flg.stk & irq_en[0]) | (st_q.flg.sltf & irq_en[1]);

    // R9
    hto_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flg.hto && !flag_clr[0]) |=> st_q.flg.hto);

    // R6
    sltf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flg.sltf) |-> (st_q.flg.mext || st_q.flg.sext));

    // R8
    abort_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flg.abort) |-> $past(ack_evt || stop_evt));

    // R6
    mext_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flg.mext) |-> $past(master_mode));
endmodule

// File: tb/smbus_tmo_mon_bench.sv
`timescale 1ns/1ps
module smbus_tmo_mon_bench;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic scl_in = 1'b0, sda_in = 1'b0;
    logic stretch_req = 1'b0, own_scl_low = 1'b1;
    logic start_evt = 1'b0, stop_evt = 1'b0, ack_evt = 1'b0;
    logic master_mode = 1'b0;
    logic [CW-1:0] high_max = 16'd8, stuck_max = 16'd5;
    logic [CW-1:0] mext_max = 16'd10, sext_max = 16'd10;
    logic [1:0] irq_en = 2'b00;
    logic [5:0] flag_clr = '0;
    logic [5:0] flags;
    logic busy, bus_free, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    smbus_tmo_mon #(.CW(CW)) u_smbus_tmo_mon (
        .clk(clk), .rst_n(rst_n), .tick(tick), .scl_in(scl_in), .sda_in(sda_in),
        .stretch_req(stretch_req), .own_scl_low(own_scl_low),
        .start_evt(start_evt), .stop_evt(stop_evt), .ack_evt(ack_evt),
        .master_mode(master_mode), .high_max(high_max), .stuck_max(stuck_max),
        .mext_max(mext_max), .sext_max(sext_max), .irq_en(irq_en),
        .flag_clr(flag_clr), .flags(flags), .busy(busy), .bus_free(bus_free),
        .irq(irq)
    );

    // {scl, sda, hold[7:0], exp_high, exp_stuck}
    localparam logic [11:0] VEC [8] = '{
        {1'b1, 1'b1, 8'd20, 1'b1, 1'b0},
        {1'b1, 1'b1, 8'd6,  1'b0, 1'b0},
        {1'b1, 1'b0, 8'd20, 1'b0, 1'b1},
        {1'b1, 1'b0, 8'd3,  1'b0, 1'b0},
        {1'b0, 1'b1, 8'd20, 1'b0, 1'b0},
        {1'b0, 1'b0, 8'd20, 1'b0, 1'b0},
        {1'b1, 1'b0, 8'd9,  1'b0, 1'b1},
        {1'b1, 1'b1, 8'd12, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        flag_clr = 6'h3F; cyc(1); flag_clr = '0; cyc(1);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1; cyc(1); s = 1'b0; cyc(1);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R9 reset state
        chk("R9 reset flags", flags, 0);
        chk("R9 reset busy", busy, 0);
        chk("R5 reset irq", irq, 0);

        // R2 / R4 level table
        for (int i = 0; i < 8; i++) begin
            scl_in = VEC[i][11]; sda_in = VEC[i][10];
            cyc(int'(VEC[i][9:2]));
            scl_in = 1'b0; sda_in = 1'b0;
            cyc(4);
            chk($sformatf("R2 vec%0d high flag", i), flags[0], VEC[i][1]);
            chk($sformatf("R4 vec%0d stuck flag", i), flags[1], VEC[i][0]);
            clear_all();
        end

        // R2 restart on one broken sample
        scl_in = 1; sda_in = 1; cyc(6);
        sda_in = 0; cyc(1);
        sda_in = 1; cyc(6);
        scl_in = 0; sda_in = 0; cyc(4);
        chk("R2 restart high", flags[0], 0);
        clear_all();

        // R1 tick gating
        tick = 1'b0;
        scl_in = 1; sda_in = 1; cyc(30);
        chk("R1 no tick high", flags[0], 0);
        sda_in = 0; cyc(30);
        chk("R1 no tick stuck", flags[1], 0);
        scl_in = 0; tick = 1'b1; cyc(4);
        clear_all();

        // R5 interrupt gating
        scl_in = 1; sda_in = 0; cyc(20);
        scl_in = 0; cyc(4);
        chk("R5 irq masked", irq, 0);
        irq_en = 2'b01; cyc(1);
        chk("R5 irq stuck enabled", irq, 1);
        irq_en = 2'b10; cyc(1);
        chk("R5 irq other enable", irq, 0);
        irq_en = 2'b00;
        clear_all();

        // R9 clear and set same cycle
        scl_in = 1; sda_in = 1; cyc(20);
        chk("R9 high set", flags[0], 1);
        flag_clr = 6'h01; cyc(1); flag_clr = '0; cyc(1);
        chk("R9 set wins over clear", flags[0], 1);
        scl_in = 0; sda_in = 0; cyc(4);
        clear_all();
        chk("R9 cleared", flags, 0);

        // R3 busy / bus free
        pulse(start_evt);
        chk("R3 busy after start", busy, 1);
        chk("R3 not free", bus_free, 0);
        scl_in = 1; sda_in = 1; cyc(20);
        chk("R3 free busy+high", bus_free, 1);
        pulse(stop_evt); cyc(1);
        chk("R3 busy after stop", busy, 0);
        chk("R3 free after stop", bus_free, 0);
        scl_in = 0; sda_in = 0; cyc(4);
        clear_all();

        // R6 master per-byte accumulation
        master_mode = 1; own_scl_low = 1; irq_en = 2'b10;
        pulse(start_evt);
        stretch_req = 1; cyc(6); stretch_req = 0; cyc(1);
        pulse(ack_evt);
        stretch_req = 1; cyc(6); stretch_req = 0; cyc(2);
        chk("R6 split segments mext", flags[2], 0);
        chk("R6 split segments low", flags[4], 0);
        stretch_req = 1; cyc(6); stretch_req = 0; cyc(2);
        chk("R6 mext set", flags[2], 1);
        chk("R6 low set", flags[4], 1);
        chk("R6 sext clear", flags[3], 0);
        chk("R5 irq low timeout", irq, 1);

        // R7 slave per-message accumulation
        pulse(start_evt);
        master_mode = 0;
        clear_all();
        stretch_req = 1; cyc(6); stretch_req = 0; cyc(1);
        pulse(ack_evt);
        stretch_req = 1; cyc(6); stretch_req = 0; cyc(2);
        chk("R7 sext set", flags[3], 1);
        chk("R7 low set", flags[4], 1);
        chk("R7 mext clear", flags[2], 0);
        pulse(stop_evt);
        irq_en = 2'b00;
        clear_all();

        // R8 abort at byte boundary
        master_mode = 1; own_scl_low = 0; scl_in = 1; sda_in = 1;
        pulse(start_evt);
        scl_in = 0; cyc(15); scl_in = 1; cyc(3);
        chk("R8 abort not early", flags[5], 0);
        pulse(ack_evt);
        chk("R8 abort at ack", flags[5], 1);
        pulse(stop_evt);
        own_scl_low = 1; master_mode = 0;
        scl_in = 0; sda_in = 0; cyc(4);
        clear_all();

        // R10 saturation
        high_max = 16'hFFFF;
        scl_in = 1; sda_in = 1; cyc(65545);
        flag_clr = 6'h01; cyc(1); flag_clr = '0; cyc(2);
        chk("R10 saturated refire", flags[0], 1);
        scl_in = 0; sda_in = 0; cyc(4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule